// File: doc/BRIEF.md
# Byte-Step I2C Master Engine

This block is an I2C bus master that a host steers one byte at a time. The host writes one 16-bit command word. The word carries a start request, a stop request, the acknowledge level to return and the byte to send. The engine then runs the requested bus step. A step is a START (or a repeated START) followed by a nine-clock byte phase, a plain nine-clock byte phase, or a STOP. At the end of every ninth clock the engine holds SCL low and raises an interrupt. The host reads the status word and clears the interrupt through a separate control write. It then issues the next command.

The byte after a START is treated as an address. If its lowest bit (read/write) is 1 and the slave pulls the ninth clock low, the engine turns into a receiver. In that mode it releases SDA for the data bits and drives the acknowledge bit from the command word. SCL and SDA are open-drain. A high `*_oe` pulls the line low, and `*_in` samples the wired line.

The controller is a single state machine with these states:
- `ST_IDLE`: bus free.
- `ST_HOLD`: bus owned, SCL held low.
- `ST_RS_LOW`: SDA released while SCL is low, ahead of a repeated START.
- `ST_ST_HIGH`: both lines released.
- `ST_ST_FALL`: SDA pulled low while SCL is high, which is the START.
- `ST_BIT_LO` and `ST_BIT_HI`: the two halves of each bit clock.
- `ST_SP_LOW`, `ST_SP_HIGH`, `ST_SP_RISE`: the STOP sequence.

The transitions are:
- From `ST_IDLE`, a start command leads to `ST_ST_HIGH`.
- From `ST_HOLD`, a start command leads to `ST_RS_LOW`, a stop command to `ST_SP_LOW`, and any other command to `ST_BIT_LO`.
- `ST_RS_LOW` → `ST_ST_HIGH` → `ST_ST_FALL` → `ST_BIT_LO`.
- `ST_BIT_LO` ↔ `ST_BIT_HI` for the nine bits; after the ninth `ST_BIT_HI` the state returns to `ST_HOLD`.
- `ST_SP_LOW` → `ST_SP_HIGH` → `ST_SP_RISE` → `ST_IDLE`.

Every timed state lasts `HALF_CYC` system clocks.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both `scl_oe` and `sda_oe` are 0, `irq` is 0 and the status busy bit (bit 9) is 0.
- R2: A command write is `bus_wr`=1 with `bus_sel`=0. The command fields are: bit 10 start request, bit 9 stop request, bit 8 acknowledge level, bits 7:0 byte. A start command from idle releases both lines for one half period. It then pulls SDA low with SCL released for one half period, and then begins the byte. Every timed half period is `HALF_CYC` clocks.
- R3: When transmitting, the byte goes out MSB first. Each bit is SCL low for a half period, then SCL released for a half period, and SDA is stable while SCL is released. On the ninth clock SDA is released, and the sampled line level is stored in status bit 8 (0 = slave acknowledged).
- R4: An address byte with bit 0 = 1 whose ninth clock samples low sets receive mode (status bit 10). In receive mode SDA is released for the eight data bits. The sampled byte, MSB first, appears in status bits 7:0.
- R5: In receive mode the ninth clock drives the command's bit 8. A 0 pulls SDA low (acknowledge). A 1 releases it (not-acknowledge).
- R6: `irq` rises exactly when the ninth clock of a byte phase ends, and SCL is then held low. A write with `bus_sel`=1 and data bit 0 = 1 clears `irq`.
- R7: A start command while the bus is held performs a repeated START. SCL stays low with SDA released for a half period, then the START sequence of R2 follows. Receive mode is cleared.
- R8: A stop command (bit 9 = 1, bit 10 = 0) while the bus is held performs the STOP sequence below, then goes idle without raising `irq`. Receive mode is cleared.
  - SDA low with SCL low for a half period.
  - SCL released for a half period.
  - SDA released for a half period.
- R9: Command writes during a START, byte or STOP sequence are ignored, and the bus waveform is unchanged.
- R10: While the bus is idle, command writes without bit 10 set are ignored, and both lines stay released.
- R11: Status bit 9 (busy) is 1 from the accepted start command until the STOP sequence completes. Status bit 11 shows a sequence in progress, and bit 12 shows the sampled SCL level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 = command word, 1 = interrupt control |
| bus_wdata | input | 16 | Write data |
| status | output | 16 | Received byte and bus state |
| irq | output | 1 | Interrupt request, held until cleared |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line |

## Verification
The embedded properties watch several things on every cycle:
- SDA may not move while SCL is released inside a bit.
- SDA may fall with SCL high only in the START state.
- The interrupt may rise only at the end of a ninth clock.
- A command arriving mid-sequence must not disturb the bit counter.
- Receive mode may be entered only after an acknowledged read address.
- A finished STOP must leave both lines released.

Only the bench's scenarios can show that the waveform as a whole is right. It compares every half period of START, repeated START, data, acknowledge and STOP against a behavioural model. The scenarios also show that the received bytes and acknowledge flags reach the status word, and that ignored commands leave the lines untouched.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
    localparam int unsigned BYTE_W        = 8;
    localparam int unsigned IDX_W         = 4;
    localparam int unsigned CMD_ACK_BIT   = 8;
    localparam int unsigned CMD_STOP_BIT  = 9;
    localparam int unsigned CMD_START_BIT = 10;
    localparam int unsigned STS_ACK_BIT   = 8;
    localparam int unsigned STS_BUSY_BIT  = 9;
    localparam int unsigned STS_RX_BIT    = 10;
    localparam int unsigned STS_PHASE_BIT = 11;
    localparam int unsigned STS_SCL_BIT   = 12;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RS_LOW,
        ST_ST_HIGH,
        ST_ST_FALL,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_SP_LOW,
        ST_SP_HIGH,
        ST_SP_RISE
    } bm_state_e;
endpackage

// File: rtl/i2cbm_half_timer.sv
module i2cbm_half_timer #(
    parameter int unsigned HALF_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/i2cbm_shifter.sv
module i2cbm_shifter
    import i2cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] tx_in,
    input  logic              step,
    input  logic              sda_s,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              tx_bit,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_bit
);
    localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(BYTE_W);

    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic [IDX_W-1:0]  idx_q;
    logic              ack_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            rx_q  <= '0;
            idx_q <= '0;
            ack_q <= 1'b1;
        end else if (load) begin
            tx_q  <= tx_in;
            idx_q <= '0;
        end else if (step) begin
            if (idx_q < ACK_IDX) begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                rx_q <= {rx_q[BYTE_W-2:0], sda_s};
            end else begin
                ack_q <= sda_s;
            end
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign bit_idx = idx_q;
    assign tx_bit  = tx_q[BYTE_W-1];
    assign rx_byte = rx_q;
    assign ack_bit = ack_q;

    // R3
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (idx_q <= ACK_IDX));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cbm_pkg::*;
#(
    parameter int unsigned HALF_CYC = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_sel,
    input  logic [15:0] bus_wdata,
    output logic [15:0] status,
    output logic        irq,
    output logic        scl_oe,
    input  logic        scl_in,
    output logic        sda_oe,
    input  logic        sda_in
);
    localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(BYTE_W);

    bm_state_e         state_q, state_d;
    logic              cmd_wr, icr_wr, w_start, w_stop;
    logic              in_phase, tick, step, last_bit, load;
    logic              ack_cmd_q, rw_q, addr_q, rx_mode_q, irq_q;
    logic              drive_low;
    logic [IDX_W-1:0]  bit_idx;
    logic              tx_bit, ack_bit;
    logic [BYTE_W-1:0] rx_byte;
    logic              unused_hi;

    assign unused_hi = &{1'b0, bus_wdata[15:11]};
    assign cmd_wr    = bus_wr && !bus_sel;
    assign icr_wr    = bus_wr && bus_sel && bus_wdata[0];
    assign w_start   = bus_wdata[CMD_START_BIT];
    assign w_stop    = bus_wdata[CMD_STOP_BIT];
    assign in_phase  = (state_q != ST_IDLE) && (state_q != ST_HOLD);
    assign step      = (state_q == ST_BIT_HI) && tick;
    assign last_bit  = (bit_idx == ACK_IDX);
    assign load      = cmd_wr && (((state_q == ST_IDLE) && w_start) ||
                                  ((state_q == ST_HOLD) && (w_start || !w_stop)));

    i2cbm_half_timer #(.HALF_CYC(HALF_CYC)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (in_phase),
        .tick (tick)
    );

    i2cbm_shifter i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .tx_in  (bus_wdata[BYTE_W-1:0]),
        .step   (step),
        .sda_s  (sda_in),
        .bit_idx(bit_idx),
        .tx_bit (tx_bit),
        .rx_byte(rx_byte),
        .ack_bit(ack_bit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmd_wr && w_start) state_d = ST_ST_HIGH;
            ST_HOLD: begin
                if (cmd_wr) begin
                    if (w_start)     state_d = ST_RS_LOW;
                    else if (w_stop) state_d = ST_SP_LOW;
                    else             state_d = ST_BIT_LO;
                end
            end
            ST_RS_LOW:  if (tick) state_d = ST_ST_HIGH;
            ST_ST_HIGH: if (tick) state_d = ST_ST_FALL;
            ST_ST_FALL: if (tick) state_d = ST_BIT_LO;
            ST_BIT_LO:  if (tick) state_d = ST_BIT_HI;
            ST_BIT_HI:  if (tick) state_d = last_bit ? ST_HOLD : ST_BIT_LO;
            ST_SP_LOW:  if (tick) state_d = ST_SP_HIGH;
            ST_SP_HIGH: if (tick) state_d = ST_SP_RISE;
            ST_SP_RISE: if (tick) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_cmd_q <= 1'b1;
            rw_q      <= 1'b0;
            addr_q    <= 1'b0;
            rx_mode_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (load) begin
                ack_cmd_q <= bus_wdata[CMD_ACK_BIT];
                rw_q      <= bus_wdata[0];
                if (w_start) begin
                    addr_q    <= 1'b1;
                    rx_mode_q <= 1'b0;
                end
            end else if (step && last_bit && addr_q) begin
                rx_mode_q <= rw_q && !sda_in;
                addr_q    <= 1'b0;
            end else if ((state_q == ST_SP_RISE) && tick) begin
                rx_mode_q <= 1'b0;
            end
            if (step && last_bit) irq_q <= 1'b1;
            else if (icr_wr)      irq_q <= 1'b0;
        end
    end

    assign drive_low = last_bit ? (rx_mode_q && !ack_cmd_q) : (!rx_mode_q && !tx_bit);

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_HOLD:    scl_oe = 1'b1;
            ST_RS_LOW:  scl_oe = 1'b1;
            ST_ST_HIGH: ;
            ST_ST_FALL: sda_oe = 1'b1;
            ST_BIT_LO: begin scl_oe = 1'b1; sda_oe = drive_low; end
            ST_BIT_HI:  sda_oe = drive_low;
            ST_SP_LOW: begin scl_oe = 1'b1; sda_oe = 1'b1; end
            ST_SP_HIGH: sda_oe = 1'b1;
            ST_SP_RISE: ;
            default:    ;
        endcase
    end

    assign irq = irq_q;
    always_comb begin
        status                 = '0;
        status[BYTE_W-1:0]     = rx_byte;
        status[STS_ACK_BIT]    = ack_bit;
        status[STS_BUSY_BIT]   = (state_q != ST_IDLE);
        status[STS_RX_BIT]     = rx_mode_q;
        status[STS_PHASE_BIT]  = in_phase;
        status[STS_SCL_BIT]    = scl_in;
    end

    // R3
    sda_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT_HI && $past(state_q) == ST_BIT_HI) |-> $stable(sda_oe));
    // R7
    start_only_in_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe && $past(!scl_oe)) |-> (state_q == ST_ST_FALL));
    // R6
    irq_after_ninth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state_q == ST_BIT_HI && bit_idx == ACK_IDX));
    // R9
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_phase && cmd_wr && !tick) |=> $stable(bit_idx));
    // R4
    rx_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_mode_q) |-> $past(rw_q && !sda_in));
    // R8
    stop_frees_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[STS_BUSY_BIT]) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
    localparam int CLK_PERIOD = 10;
    localparam int H = 4;

    typedef struct packed { logic scl; logic sda; logic pull; } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_sel = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] status;
    logic irq, scl_oe, sda_oe, scl_in, sda_in;
    logic slave_pull = 1'b0;
    int errors = 0, checks = 0;
    bit done = 1'b0;
    ent_t expq[$];

    assign sda_in = !(sda_oe || slave_pull);
    assign scl_in = !scl_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_byte_master #(.HALF_CYC(H)) i_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .status(status), .irq(irq),
        .scl_oe(scl_oe), .scl_in(scl_in), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_half(input logic s, input logic d, input logic p);
        repeat (H) expq.push_back(ent_t'({s, d, p}));
    endtask

    task automatic model_start(input bit from_idle);
        if (!from_idle) push_half(1'b1, 1'b0, 1'b0);
        push_half(1'b0, 1'b0, 1'b0);
        push_half(1'b0, 1'b1, 1'b0);
    endtask

    task automatic model_byte(input bit rx, input logic [7:0] data, input bit ackcmd,
                              input bit sl_ack, input logic [7:0] sdata);
        for (int k = 0; k < 8; k++) begin
            logic d, p;
            d = rx ? 1'b0 : !data[7-k];
            p = rx ? !sdata[7-k] : 1'b0;
            push_half(1'b1, d, p);
            push_half(1'b0, d, p);
        end
        push_half(1'b1, rx ? !ackcmd : 1'b0, rx ? 1'b0 : sl_ack);
        push_half(1'b0, rx ? !ackcmd : 1'b0, rx ? 1'b0 : sl_ack);
    endtask

    task automatic model_stop();
        push_half(1'b1, 1'b1, 1'b0);
        push_half(1'b0, 1'b1, 1'b0);
        push_half(1'b0, 1'b0, 1'b0);
    endtask

    task automatic write(input logic sel, input logic [15:0] word);
        bus_sel = sel; bus_wdata = word; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic drain(input string tag, input int inj_at, input logic [15:0] inj_word);
        int i;
        i = 0;
        while (expq.size() > 0) begin
            ent_t e;
            e = expq.pop_front();
            slave_pull = e.pull;
            chk(tag, {scl_oe, sda_oe}, {e.scl, e.sda});
            if (i == inj_at) begin
                bus_sel = 1'b0; bus_wdata = inj_word; bus_wr = 1'b1;
            end else begin
                bus_wr = 1'b0;
            end
            i++;
            @(negedge clk);
        end
        slave_pull = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic check_hold(input string tag);
        chk({tag, " hold lines"}, {scl_oe, sda_oe}, 2'b10);
        chk({tag, " R6 irq"}, irq, 1);
        chk({tag, " R11 busy"}, status[9], 1);
    endtask

    task automatic clear_irq();
        write(1'b1, 16'h0001);
        chk("R6 irq clear", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 lines", {scl_oe, sda_oe}, 0);
        chk("R1 irq", irq, 0);
        chk("R1 busy", status[9], 0);

        // R10 idle commands without start are ignored
        write(1'b0, 16'h00A5);
        write(1'b0, 16'h0200);
        repeat (2 * H) begin
            chk("R10 idle lines", {scl_oe, sda_oe}, 0);
            @(negedge clk);
        end
        chk("R10 busy", status[9], 0);

        // R2 R3 start and write address, slave acknowledges
        model_start(1'b1);
        model_byte(1'b0, 8'hA0, 1'b0, 1'b1, 8'h00);
        write(1'b0, 16'h04A0);
        drain("R2 R3 start+addr", -1, 16'h0);
        check_hold("R2");
        chk("R3 slave ack", status[8], 0);
        chk("R4 still tx", status[10], 0);
        clear_irq();

        // R9 data byte with slave nack, command injected mid-phase
        model_byte(1'b0, 8'h3C, 1'b0, 1'b0, 8'h00);
        write(1'b0, 16'h003C);
        drain("R9 R3 data", 5, 16'h04FF);
        check_hold("R9");
        chk("R3 slave nack", status[8], 1);
        clear_irq();

        // R7 repeated start with read address
        model_start(1'b0);
        model_byte(1'b0, 8'hA1, 1'b0, 1'b1, 8'h00);
        write(1'b0, 16'h04A1);
        drain("R7 rep start", -1, 16'h0);
        check_hold("R7");
        chk("R4 rx mode", status[10], 1);
        clear_irq();

        // R4 R5 receive with acknowledge
        model_byte(1'b1, 8'h00, 1'b0, 1'b0, 8'h85);
        write(1'b0, 16'h0000);
        drain("R4 R5 rx ack", -1, 16'h0);
        check_hold("R5");
        chk("R4 rx byte", status[7:0], 8'h85);
        chk("R5 ack low", status[8], 0);
        clear_irq();

        // R5 receive last byte with not-acknowledge
        model_byte(1'b1, 8'h00, 1'b1, 1'b0, 8'h33);
        write(1'b0, 16'h0100);
        drain("R5 rx nack", -1, 16'h0);
        check_hold("R5n");
        chk("R4 rx byte2", status[7:0], 8'h33);
        chk("R5 nack", status[8], 1);
        clear_irq();

        // R8 stop
        model_stop();
        write(1'b0, 16'h0300);
        drain("R8 stop", -1, 16'h0);
        chk("R8 lines free", {scl_oe, sda_oe}, 0);
        chk("R8 no irq", irq, 0);
        chk("R11 busy clear", status[9], 0);
        chk("R8 rx cleared", status[10], 0);
        chk("R11 scl level", status[12], 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule